// File: doc/BRIEF.md
# High-speed clock prescaler with control register

This block holds one 8-bit control register on a simple synchronous register bus and uses it to derive two divided clocks from a single oscillator clock. The system clock and the port output clock each get their own ratio of 1, 2, 4 or 8. Both divided clocks appear as single-cycle enable strobes in the oscillator clock domain, and downstream logic gates its work with them. The register also holds a 2-bit oscillator mode. That mode goes to the oscillator logic, and it also decides whether the system ratio of 1 is allowed.

Software reaches the register with byte or halfword accesses. In a halfword access the register uses only the low byte; the high byte belongs to a neighbouring register. An oscillator-enable input from a companion register locks the mode field while the high-speed oscillator runs. A change of ratio waits for the end of the divided period that is in progress, so no enable period is ever cut short.

Top module: `hsclk_prescaler`

## Requirements
- R1: After reset the register reads 0x33: system ratio /8, output ratio /8, mode RC (00), bits [7:6] zero.
- R2: Bits [1:0] pick the system ratio (00=/1, 01=/2, 10=/4, 11=/8). With ratio N settled, `sys_clk_en_o` is high in exactly the cycles where (cycles since reset) mod N equals N-1.
- R3: While the mode field is 10 (PLL), system code 00 gives /2 instead of /1. The other codes are unchanged.
- R4: Bits [3:2] hold the oscillator mode (00=RC, 01=crystal, 10=PLL, 11=external), and `osc_mode_o` shows them.
- R5: While `osc_en_i` is 1, a write leaves bits [3:2] unchanged. Bits [1:0] and [5:4] of the same write still update.
- R6: Bits [5:4] pick the output ratio with the same codes and timing as R2. The PLL mode does not change this ratio.
- R7: Bits [7:6] always read 0 and ignore writes.
- R8: The register sits at 0xF002. A write lands on a byte access to 0xF002 or on a halfword access to 0xF002/0xF003, and uses only wdata[7:0]. A byte access to 0xF003 and an access to any other address leave the register unchanged.
- R9: In the same cycle as a read that hits the register, `bus_rdata_o` returns {8'h00, register}. In every other cycle it is 0.
- R10: The first edge a new ratio can act on is the one right after an enable pulse of the old ratio. The following enable then falls on the next counter boundary of the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access valid |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 1 | 0 = byte, 1 = halfword |
| bus_addr_i | input | 16 | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational |
| osc_en_i | input | 1 | High-speed oscillator enabled, locks the mode field |
| sys_clk_en_o | output | 1 | System clock enable strobe |
| out_clk_en_o | output | 1 | Port output clock enable strobe |
| osc_mode_o | output | 2 | Oscillator mode field |

## Verification
The assertions check four things on every cycle. Bits [7:6] and the high byte of the read data stay zero, and the read data is zero in every cycle without a read hit. The mode output never changes after a cycle in which the oscillator was enabled. No write that misses the register changes it. The cycle-exact alignment of the enable strobes, the PLL substitution for /1, and the boundary-timed switch between ratios need the bench's reference model. That model tracks its own cycle count and the pending ratios through scripted sequences of writes.

// File: rtl/hsclk_pkg.sv
package hsclk_pkg;
  typedef enum logic [1:0] {
    OSC_RC   = 2'b00,
    OSC_XTAL = 2'b01,
    OSC_PLL  = 2'b10,
    OSC_EXT  = 2'b11
  } osc_mode_e;

  typedef struct packed {
    logic [1:0] rsvd;
    logic [1:0] out_sel;
    osc_mode_e  mode;
    logic [1:0] sys_sel;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rsvd: 2'b00, out_sel: 2'b11, mode: OSC_RC, sys_sel: 2'b11};
endpackage

// File: rtl/hsclk_bus_dec.sv
module hsclk_bus_dec
  import hsclk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF002
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  ctrl_t             reg_i,
  output logic              wr_o,
  output logic [7:0]        wbyte_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - 8;

  logic hit;

  // halfword covers the pair; byte only the even lane
  assign hit     = sel_i && (addr_i[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1]) && (size_i || !addr_i[0]);
  assign wr_o    = hit && we_i;
  assign wbyte_o = wdata_i[7:0];
  assign rdata_o = (hit && !we_i) ? {{PAD_W{1'b0}}, reg_i} : '0;
endmodule

// File: rtl/hsclk_ctrl_reg.sv
module hsclk_ctrl_reg
  import hsclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wbyte_i,
  input  logic       osc_en_i,
  output ctrl_t      q_o
);
  ctrl_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= CTRL_RST;
    end else if (wr_i) begin
      q.sys_sel <= wbyte_i[1:0];
      q.out_sel <= wbyte_i[5:4];
      if (!osc_en_i) q.mode <= osc_mode_e'(wbyte_i[3:2]);
      q.rsvd <= 2'b00;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/hsclk_tick_cnt.sv
module hsclk_tick_cnt #(
  parameter int SEL_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [2**SEL_W-1:0] ticks_o
);
  localparam int NT    = 2 ** SEL_W;
  localparam int CNT_W = NT - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // ticks_o[k]: last cycle of a 2**k period
  assign ticks_o[0] = 1'b1;
  for (genvar k = 1; k < NT; k++) begin : g_tick
    assign ticks_o[k] = &cnt_q[k-1:0];
  end
endmodule

// File: rtl/hsclk_div_sel.sv
module hsclk_div_sel #(
  parameter int SEL_W = 2,
  parameter logic [SEL_W-1:0] RST_SEL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2**SEL_W-1:0] ticks_i,
  input  logic [SEL_W-1:0]    req_sel_i,
  output logic                en_o
);
  logic [SEL_W-1:0] act_q;

  assign en_o = ticks_i[act_q];

  // take the new ratio only as the running period closes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   act_q <= RST_SEL;
    else if (en_o) act_q <= req_sel_i;
  end
endmodule

// File: rtl/hsclk_prescaler.sv
module hsclk_prescaler
  import hsclk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF002
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic              bus_size_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              osc_en_i,
  output logic              sys_clk_en_o,
  output logic              out_clk_en_o,
  output logic [1:0]        osc_mode_o
);
  localparam int SEL_W = 2;
  localparam int NT    = 2 ** SEL_W;

  ctrl_t            ctrl;
  logic             wr;
  logic [7:0]       wbyte;
  logic [NT-1:0]    ticks;
  logic [SEL_W-1:0] sys_req;

  hsclk_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_dec (
    .sel_i(bus_sel_i), .we_i(bus_we_i), .size_i(bus_size_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .reg_i(ctrl), .wr_o(wr), .wbyte_o(wbyte), .rdata_o(bus_rdata_o)
  );

  hsclk_ctrl_reg u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr), .wbyte_i(wbyte), .osc_en_i(osc_en_i), .q_o(ctrl)
  );

  hsclk_tick_cnt #(.SEL_W(SEL_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .ticks_o(ticks)
  );

  // PLL mode: /1 is not allowed for the system clock
  assign sys_req = (ctrl.mode == OSC_PLL && ctrl.sys_sel == '0) ? SEL_W'(1) : ctrl.sys_sel;

  hsclk_div_sel #(.SEL_W(SEL_W), .RST_SEL(CTRL_RST.sys_sel)) u_sys (
    .clk_i(clk_i), .rst_ni(rst_ni), .ticks_i(ticks), .req_sel_i(sys_req), .en_o(sys_clk_en_o)
  );

  hsclk_div_sel #(.SEL_W(SEL_W), .RST_SEL(CTRL_RST.out_sel)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .ticks_i(ticks), .req_sel_i(ctrl.out_sel), .en_o(out_clk_en_o)
  );

  assign osc_mode_o = ctrl.mode;
endmodule

// File: rtl/hsclk_prescaler_chk.sv
module hsclk_prescaler_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hF002
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_sel_i,
  input logic              bus_we_i,
  input logic              bus_size_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              osc_en_i,
  input logic              sys_clk_en_o,
  input logic              out_clk_en_o,
  input logic [1:0]        osc_mode_o
);
  logic hit;
  assign hit = bus_sel_i && (bus_addr_i[ADDR_W-1:1] == REG_ADDR[ADDR_W-1:1])
               && (bus_size_i || !bus_addr_i[0]);

  a_r7_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[7:6] == 2'b00);

  a_r9_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:8] == '0);

  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit && !bus_we_i) |-> bus_rdata_o == '0);

  a_r5_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(osc_en_i) |-> $stable(osc_mode_o));

  a_r8_miss_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(hit && bus_we_i)) |-> $stable(osc_mode_o));
endmodule

bind hsclk_prescaler hsclk_prescaler_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)) u_chk (.*);

// File: tb/tb_hsclk_prescaler.sv
module tb_hsclk_prescaler;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0, bus_size = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        osc_en = 1'b0;
  logic        sys_en, out_en;
  logic [1:0]  mode;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_reg;
  int m_cnt, m_sdiv, m_odiv;

  always #5 clk = ~clk;

  hsclk_prescaler dut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_sel_i(bus_sel), .bus_we_i(bus_we), .bus_size_i(bus_size),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .osc_en_i(osc_en),
    .sys_clk_en_o(sys_en), .out_clk_en_o(out_en), .osc_mode_o(mode)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_hit();
    return bus_sel && (bus_addr[15:1] == 15'h7801) && (bus_size || !bus_addr[0]);
  endfunction

  function automatic int code_div(logic [1:0] c);
    return 1 << c;
  endfunction

  function automatic bit m_en(int d);
    return (m_cnt % d) == d - 1;
  endfunction

  // reference model: advances on each edge from sampled inputs
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_reg = 8'h33; m_cnt = 0; m_sdiv = 8; m_odiv = 8;
    end else begin
      int rs, ro;
      rs = (m_reg[3:2] == 2'b10 && m_reg[1:0] == 2'b00) ? 2 : code_div(m_reg[1:0]);
      ro = code_div(m_reg[5:4]);
      if (m_en(m_sdiv)) m_sdiv = rs;
      if (m_en(m_odiv)) m_odiv = ro;
      if (m_hit() && bus_we) begin
        m_reg[1:0] = bus_wdata[1:0];
        m_reg[5:4] = bus_wdata[5:4];
        if (!osc_en) m_reg[3:2] = bus_wdata[3:2];
      end
      m_cnt = (m_cnt + 1) % 8;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R2 R3 R10 sys_clk_en", {15'd0, sys_en}, {15'd0, m_en(m_sdiv)});
      chk("R6 R10 out_clk_en", {15'd0, out_en}, {15'd0, m_en(m_odiv)});
      chk("R4 osc_mode", {14'd0, mode}, {14'd0, m_reg[3:2]});
      chk("R9 rdata", bus_rdata, (m_hit() && !bus_we) ? {8'h00, m_reg} : 16'h0000);
    end
  end

  task automatic wr(logic [15:0] a, logic sz, logic [15:0] d);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b1; bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [15:0] a, logic [15:0] exp);
    @(negedge clk); #1;
    bus_sel = 1'b1; bus_we = 1'b0; bus_size = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic count_chk(string tag, bit use_sys, int exp);
    int n = 0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      if (use_sys ? sys_en : out_en) n++;
    end
    chk(tag, 16'(n), 16'(exp));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    rd_chk("R1 reset value", 16'hF002, 16'h0033);
    chk("R1 reset mode", {14'd0, mode}, 16'h0000);
    count_chk("R1 R2 sys /8 after reset", 1, 4);
    count_chk("R1 R6 out /8 after reset", 0, 4);

    wr(16'hF002, 1'b0, 16'h0020);              // sys /1, out /4, RC
    count_chk("R2 sys /1", 1, 32);
    count_chk("R6 out /4", 0, 8);
    wr(16'hF002, 1'b0, 16'h0002);              // sys /4, out /1
    count_chk("R2 R10 sys /4", 1, 8);
    count_chk("R6 out /1", 0, 32);

    wr(16'hF002, 1'b0, 16'h0008);              // PLL, sys code 00, out code 00
    chk("R4 mode PLL", {14'd0, mode}, 16'h0002);
    count_chk("R3 PLL sys code 00 gives /2", 1, 16);
    count_chk("R6 out unaffected by PLL", 0, 32);

    wr(16'hF002, 1'b0, 16'h00FF);
    rd_chk("R7 upper bits read zero", 16'hF002, 16'h003F);
    chk("R4 mode external", {14'd0, mode}, 16'h0003);
    wr(16'hF002, 1'b0, 16'h0008);

    osc_en = 1'b1;
    wr(16'hF002, 1'b0, 16'h0035);
    rd_chk("R5 mode locked, others written", 16'hF002, 16'h0039);
    count_chk("R5 sys /2 written while locked", 1, 16);

    wr(16'hF003, 1'b0, 16'h0000);
    rd_chk("R8 odd byte write ignored", 16'hF002, 16'h0039);
    wr(16'hF002, 1'b1, 16'h2200);
    rd_chk("R8 halfword low byte only", 16'hF002, 16'h0008);
    wr(16'hF004, 1'b0, 16'h0033);
    rd_chk("R8 other address ignored", 16'hF002, 16'h0008);
    rd_chk("R9 read miss returns zero", 16'hF000, 16'h0000);
    rd_chk("R9 odd byte read miss", 16'hF003, 16'h0000);

    osc_en = 1'b0;
    wr(16'hF002, 1'b0, 16'h0030);              // RC, sys /1, out /8
    count_chk("R3 RC mode allows /1", 1, 32);
    wr(16'hF002, 1'b0, 16'h0013);              // sys /8, out /2
    count_chk("R10 sys back to /8", 1, 4);
    count_chk("R6 out /2", 0, 16);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule